// File: doc/BRIEF.md
# Two-Cycle Flash Command Interface

This block is the command register and mode controller of a byte-wide parallel flash memory. It samples the active-low chip-enable, output-enable and write-enable pins, an 18-bit address, an 8-bit data bus and a flag that shows whether the high programming supply is present. All of these inputs are first synchronised to a system clock. Write-enable transitions are detected as edges on that clock and are never used as clocks themselves.

Command bytes are captured on the write-enable rising edge. Some commands take effect at once. Erase, program and reset need a second write cycle. The block decides what the read path returns: array data, a two-byte signature, or array data at a latched verify address. It also issues single-cycle pulses to the external timing logic:

- erase start
- program start
- operation stop
- abort
- command error

The address and data latched for programming are held on dedicated outputs. A small memory in the testbench stands in for the array.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the interface is in array-read mode, with no latched address or data. A read returns the array byte at the address on the pins.
- R2: The data output is enabled only while chip-enable and output-enable are low and write-enable is high. Otherwise it is off.
- R3: While the programming-supply flag is low, write cycles change nothing. The state after the supply returns is the state from before.
- R4: Command 0x00 selects array read. Command 0x90 selects signature mode, where an even address reads 0x31 and an odd address reads 0xBD.
- R5: An erase starts only when 0x20 is written in two consecutive write cycles. If the second byte differs, no erase starts.
- R6: After command 0x40, the next write cycle latches the address present at the write-enable falling edge and the data present at the rising edge. The rising edge also pulses program start.
- R7: Command 0xA0 enters erase verify and latches the address given at its rising edge. Reads then return the array byte at that latched address, whatever address is on the pins.
- R8: Command 0xC0 enters program verify and keeps the address latched by the program cycle. Reads return the array byte at that address.
- R9: Two consecutive 0xFF writes pulse abort and return to array read. Any write accepted while an erase or program is running pulses operation stop.
- R10: An unrecognised first byte, or a second byte that does not complete its command, pulses command error and returns to array read.
- R11: Each pulse output is high for exactly one clock per triggering write. Erase start, program start, abort and command error never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| vpp_hi | input | 1 | High programming supply present |
| addr | input | 18 | Byte address from the pins |
| din | input | 8 | Data bus input |
| arr_data | input | 8 | Byte read from the array at arr_addr |
| arr_addr | output | 18 | Address presented to the array |
| dout | output | 8 | Read data toward the pins |
| dout_en | output | 1 | Output drive enable |
| erase_start | output | 1 | One-cycle pulse: begin erase |
| prog_start | output | 1 | One-cycle pulse: begin program |
| op_stop | output | 1 | One-cycle pulse: end running operation |
| abort | output | 1 | One-cycle pulse: abort and reset |
| cmd_err | output | 1 | One-cycle pulse: bad command sequence |
| lat_addr | output | 18 | Latched program or verify address |
| lat_data | output | 8 | Latched program data |

## Verification
A wrong mode state shows up on the very next read cycle. The data output then carries array data where a signature or verify byte is expected, or the reverse. It can also come from the pin address instead of the latched one. A half-finished two-cycle sequence is caught on the second write. In that case the start or abort pulse is missing, or an error pulse appears where none is expected. The synchroniser depth plus one register stage after the write-enable rising edge bounds how soon this is visible. A falling-edge latch that samples at the wrong edge shows up as a wrong lat_addr value once the program cycle completes.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam int CMD_W = 8;

   localparam logic [CMD_W-1:0] OP_READ   = 8'h00;
   localparam logic [CMD_W-1:0] OP_SIG    = 8'h90;
   localparam logic [CMD_W-1:0] OP_ERASE  = 8'h20;
   localparam logic [CMD_W-1:0] OP_EVFY   = 8'hA0;
   localparam logic [CMD_W-1:0] OP_PROG   = 8'h40;
   localparam logic [CMD_W-1:0] OP_PVFY   = 8'hC0;
   localparam logic [CMD_W-1:0] OP_RESET  = 8'hFF;

   localparam logic [CMD_W-1:0] SIG_MAKER = 8'h31;
   localparam logic [CMD_W-1:0] SIG_PART  = 8'hBD;

   typedef enum logic [3:0] {
      ST_READ,
      ST_SIG,
      ST_ERS_SETUP,
      ST_ERASING,
      ST_ERS_VERIFY,
      ST_PRG_SETUP,
      ST_PROGRAMMING,
      ST_PRG_VERIFY,
      ST_RST_PEND
   } cmd_state_t;

endpackage

// File: rtl/flash_pin_sync.sv
module flash_pin_sync #(
   parameter int          W      = 1,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] RST   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 1) begin : g_bad_depth
      $error("flash_pin_sync: STAGES must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_s,
   input  logic              we_s,
   input  logic              vpp_s,
   input  logic [ADDR_W-1:0] addr_s,
   input  logic [DATA_W-1:0] din_s,
   output cmd_state_t        state,
   output logic              erase_start,
   output logic              prog_start,
   output logic              op_stop,
   output logic              abort,
   output logic              cmd_err,
   output logic [ADDR_W-1:0] lat_addr,
   output logic [DATA_W-1:0] lat_data
);

   logic we_prev;
   logic we_rise, we_fall;
   cmd_state_t nxt;
   logic e_nx, p_nx, s_nx, a_nx, r_nx;
   logic [ADDR_W-1:0] la_nx;
   logic [DATA_W-1:0] ld_nx;

   assign we_rise = we_s & ~we_prev & ~ce_s & vpp_s;
   assign we_fall = ~we_s & we_prev & ~ce_s & vpp_s;

   always_comb begin
      nxt   = state;
      e_nx  = 1'b0;
      p_nx  = 1'b0;
      s_nx  = 1'b0;
      a_nx  = 1'b0;
      r_nx  = 1'b0;
      la_nx = lat_addr;
      ld_nx = lat_data;
      if (we_fall && state == ST_PRG_SETUP) la_nx = addr_s;
      if (we_rise) begin
         case (state)
            ST_ERS_SETUP: begin
               if (din_s == OP_ERASE) begin
                  nxt  = ST_ERASING;
                  e_nx = 1'b1;
               end else begin
                  nxt  = ST_READ;
                  r_nx = 1'b1;
               end
            end
            ST_PRG_SETUP: begin
               nxt   = ST_PROGRAMMING;
               ld_nx = din_s;
               p_nx  = 1'b1;
            end
            ST_RST_PEND: begin
               nxt = ST_READ;
               if (din_s == OP_RESET) a_nx = 1'b1;
               else                   r_nx = 1'b1;
            end
            default: begin
               s_nx = (state == ST_ERASING) || (state == ST_PROGRAMMING);
               case (din_s)
                  OP_READ:  nxt = ST_READ;
                  OP_SIG:   nxt = ST_SIG;
                  OP_ERASE: nxt = ST_ERS_SETUP;
                  OP_PROG:  nxt = ST_PRG_SETUP;
                  OP_RESET: nxt = ST_RST_PEND;
                  OP_EVFY: begin
                     nxt   = ST_ERS_VERIFY;
                     la_nx = addr_s;
                  end
                  OP_PVFY:  nxt = ST_PRG_VERIFY;
                  default: begin
                     nxt  = ST_READ;
                     r_nx = 1'b1;
                  end
               endcase
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_READ;
         we_prev     <= 1'b1;
         erase_start <= 1'b0;
         prog_start  <= 1'b0;
         op_stop     <= 1'b0;
         abort       <= 1'b0;
         cmd_err     <= 1'b0;
         lat_addr    <= '0;
         lat_data    <= '0;
      end else begin
         state       <= nxt;
         we_prev     <= we_s;
         erase_start <= e_nx;
         prog_start  <= p_nx;
         op_stop     <= s_nx;
         abort       <= a_nx;
         cmd_err     <= r_nx;
         lat_addr    <= la_nx;
         lat_data    <= ld_nx;
      end
   end

   // R3: with the supply flag low, the mode register holds
   assert_vpp_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !vpp_s |=> $stable(state));

   // R5: an erase pulse only follows the setup state
   assert_erase_two_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |-> ($past(state) == ST_ERS_SETUP && state == ST_ERASING));

   // R8: the latched address stays put during program verify
   assert_verify_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PRG_VERIFY && $past(state) == ST_PRG_VERIFY) |-> $stable(lat_addr));

   // R11: start, abort and error pulses are mutually exclusive
   assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({erase_start, prog_start, abort, cmd_err}));

   // R9: abort always lands in array read
   assert_abort_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> state == ST_READ);

endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_s,
   input  logic              oe_s,
   input  logic              we_s,
   input  logic              vpp_s,
   input  cmd_state_t        state,
   input  logic [ADDR_W-1:0] addr_s,
   input  logic [ADDR_W-1:0] lat_addr,
   input  logic [DATA_W-1:0] arr_data,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   logic verify_sel;
   logic sig_sel;

   assign verify_sel = vpp_s && (state == ST_ERS_VERIFY || state == ST_PRG_VERIFY);
   assign sig_sel    = vpp_s && (state == ST_SIG);
   assign arr_addr   = verify_sel ? lat_addr : addr_s;
   assign dout_en    = ~ce_s & ~oe_s & we_s;

   always_comb begin
      if (sig_sel) dout = addr_s[0] ? SIG_PART : SIG_MAKER;
      else         dout = arr_data;
   end

   // R2: a deselected chip never drives
   assert_hiz_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ce_s |-> !dout_en);

   // R7: verify reads use the latched address
   assert_verify_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_s && state == ST_ERS_VERIFY) |-> arr_addr == lat_addr);

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W      = 18,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              vpp_hi,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] arr_data,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              erase_start,
   output logic              prog_start,
   output logic              op_stop,
   output logic              abort,
   output logic              cmd_err,
   output logic [ADDR_W-1:0] lat_addr,
   output logic [DATA_W-1:0] lat_data
);

   localparam int BUS_W = ADDR_W + DATA_W + 1;

   if (DATA_W != CMD_W) begin : g_bad_data
      $error("flash_cmd_if: DATA_W must equal the command width");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("flash_cmd_if: ADDR_W too small");
   end

   logic [2:0]       ctl_s;
   logic [BUS_W-1:0] bus_s;
   logic             ce_s, oe_s, we_s, vpp_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] din_s;
   cmd_state_t       state;

   flash_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b111)) i_ctl_sync (
      .clk(clk), .rst_n(rst_n), .d({ce_n, oe_n, we_n}), .q(ctl_s));

   flash_pin_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST('0)) i_bus_sync (
      .clk(clk), .rst_n(rst_n), .d({vpp_hi, addr, din}), .q(bus_s));

   assign {ce_s, oe_s, we_s}     = ctl_s;
   assign {vpp_s, addr_s, din_s} = bus_s;

   flash_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
      .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .we_s(we_s), .vpp_s(vpp_s),
      .addr_s(addr_s), .din_s(din_s), .state(state),
      .erase_start(erase_start), .prog_start(prog_start), .op_stop(op_stop),
      .abort(abort), .cmd_err(cmd_err), .lat_addr(lat_addr), .lat_data(lat_data));

   flash_read_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rd (
      .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
      .vpp_s(vpp_s), .state(state), .addr_s(addr_s), .lat_addr(lat_addr),
      .arr_data(arr_data), .arr_addr(arr_addr), .dout(dout), .dout_en(dout_en));

endmodule

// File: tb/test_flash_cmd_if.sv
module test_flash_cmd_if;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vpp_hi = 1'b1;
   logic [17:0] addr = '0;
   logic [7:0]  din = '0;
   logic [7:0]  arr_data;
   logic [17:0] arr_addr, lat_addr;
   logic [7:0]  dout, lat_data;
   logic        dout_en, erase_start, prog_start, op_stop, abort, cmd_err;

   int n_chk = 0, n_fail = 0;
   int c_ers = 0, c_prg = 0, c_stop = 0, c_abt = 0, c_err = 0;
   logic [7:0] mem [16];

   always #2 clk = ~clk;

   assign arr_data = mem[arr_addr[3:0]];

   flash_cmd_if i_flash_cmd_if (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .vpp_hi(vpp_hi), .addr(addr), .din(din), .arr_data(arr_data),
      .arr_addr(arr_addr), .dout(dout), .dout_en(dout_en),
      .erase_start(erase_start), .prog_start(prog_start), .op_stop(op_stop),
      .abort(abort), .cmd_err(cmd_err), .lat_addr(lat_addr), .lat_data(lat_data));

   always @(negedge clk) begin
      if (erase_start) c_ers++;
      if (prog_start)  c_prg++;
      if (op_stop)     c_stop++;
      if (abort)       c_abt++;
      if (cmd_err)     c_err++;
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [17:0] a_fall, logic [17:0] a_rise, logic [7:0] d);
      addr = a_fall; din = d; ce_n = 1'b0; wait_clk(4);
      we_n = 1'b0; wait_clk(4);
      addr = a_rise; wait_clk(4);
      we_n = 1'b1; wait_clk(5);
      ce_n = 1'b1; wait_clk(4);
   endtask

   task automatic rd(logic [17:0] a, output logic [7:0] d, output logic en);
      addr = a; ce_n = 1'b0; oe_n = 1'b0; wait_clk(5);
      d = dout; en = dout_en;
      oe_n = 1'b1; ce_n = 1'b1; wait_clk(4);
   endtask

   task automatic t_reset();
      logic [7:0] d; logic en;
      check("R1 lat_addr", lat_addr, 0);
      check("R1 lat_data", lat_data, 0);
      check("R2 idle dout_en", dout_en, 0);
      rd(18'd3, d, en);
      check("R1 read mode data", d, mem[3]);
      check("R2 read enable", en, 1);
      check("R11 no pulses", c_ers + c_prg + c_stop + c_abt + c_err, 0);
   endtask

   task automatic t_oe_gating();
      ce_n = 1'b0; oe_n = 1'b1; wait_clk(5);
      check("R2 oe high", dout_en, 0);
      oe_n = 1'b0; we_n = 1'b0; din = 8'h00; wait_clk(5);
      check("R2 we low", dout_en, 0);
      we_n = 1'b1; oe_n = 1'b1; wait_clk(5);
      ce_n = 1'b1; wait_clk(4);
   endtask

   task automatic t_vpp_lock();
      logic [7:0] d; logic en;
      vpp_hi = 1'b0; wait_clk(4);
      wr(18'd0, 18'd0, 8'h90);
      rd(18'd0, d, en);
      check("R3 vpp low read", d, mem[0]);
      vpp_hi = 1'b1; wait_clk(4);
      rd(18'd0, d, en);
      check("R3 write ignored", d, mem[0]);
   endtask

   task automatic t_signature();
      logic [7:0] d; logic en;
      wr(18'd0, 18'd0, 8'h90);
      rd(18'd0, d, en);
      check("R4 maker code", d, 8'h31);
      rd(18'd1, d, en);
      check("R4 part code", d, 8'hBD);
      wr(18'd0, 18'd0, 8'h00);
      rd(18'd1, d, en);
      check("R4 back to read", d, mem[1]);
   endtask

   task automatic t_erase();
      logic [7:0] d; logic en;
      int e0 = c_ers, s0 = c_stop;
      wr(18'd0, 18'd0, 8'h20);
      check("R5 single 20 no erase", c_ers, e0);
      wr(18'd0, 18'd0, 8'h20);
      check("R5 erase start", c_ers, e0 + 1);
      wr(18'd5, 18'd5, 8'hA0);
      check("R9 erase stop", c_stop, s0 + 1);
      check("R7 verify addr", lat_addr, 5);
      rd(18'd9, d, en);
      check("R7 verify data", d, mem[5]);
      wr(18'd0, 18'd0, 8'h00);
   endtask

   task automatic t_erase_mismatch();
      logic [7:0] d; logic en;
      int e0 = c_ers, r0 = c_err;
      wr(18'd0, 18'd0, 8'h20);
      wr(18'd0, 18'd0, 8'h00);
      check("R5 mismatch no erase", c_ers, e0);
      check("R10 mismatch error", c_err, r0 + 1);
      rd(18'd2, d, en);
      check("R10 mismatch read", d, mem[2]);
   endtask

   task automatic t_program();
      logic [7:0] d; logic en;
      int p0 = c_prg, s0 = c_stop;
      wr(18'd0, 18'd0, 8'h40);
      wr(18'd6, 18'h2AAAB, 8'h5A);
      check("R6 program start", c_prg, p0 + 1);
      check("R6 fall addr", lat_addr, 6);
      check("R6 rise data", lat_data, 8'h5A);
      wr(18'd1, 18'd1, 8'hC0);
      check("R9 program stop", c_stop, s0 + 1);
      check("R8 addr kept", lat_addr, 6);
      rd(18'd2, d, en);
      check("R8 verify data", d, mem[6]);
      wr(18'd0, 18'd0, 8'h00);
   endtask

   task automatic t_abort();
      logic [7:0] d; logic en;
      int a0 = c_abt, s0 = c_stop, r0 = c_err;
      wr(18'd0, 18'd0, 8'h40);
      wr(18'd7, 18'd7, 8'h33);
      wr(18'd0, 18'd0, 8'hFF);
      check("R9 stop on write", c_stop, s0 + 1);
      check("R9 no abort yet", c_abt, a0);
      wr(18'd0, 18'd0, 8'hFF);
      check("R9 abort pulse", c_abt, a0 + 1);
      check("R11 no error", c_err, r0);
      rd(18'd4, d, en);
      check("R9 read after abort", d, mem[4]);
      wr(18'd0, 18'd0, 8'hFF);
      wr(18'd0, 18'd0, 8'h90);
      check("R10 half reset error", c_err, r0 + 1);
      rd(18'd0, d, en);
      check("R10 half reset read", d, mem[0]);
   endtask

   task automatic t_unknown();
      logic [7:0] d; logic en;
      int r0 = c_err;
      wr(18'd0, 18'd0, 8'h90);
      wr(18'd0, 18'd0, 8'h55);
      check("R10 R11 one error pulse", c_err, r0 + 1);
      rd(18'd0, d, en);
      check("R10 unknown read", d, mem[0]);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 8'h10 + 8'(i * 7);
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(4);
      t_reset();
      t_oe_gating();
      t_vpp_lock();
      t_signature();
      t_erase();
      t_erase_mismatch();
      t_program();
      t_abort();
      t_unknown();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #800000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule